// File: doc/BRIEF.md
# PCI Configuration Command Register with Parity Error Qualification

This block holds the 16-bit command word of a PCI-style configuration header and the logic its bits drive. A configuration write port with byte enables updates the word; the stored value is always visible on a read port. Individual bits gate whether the device claims memory-space and I/O-space transactions and whether its master side may start transactions. Configuration transactions are claimed unconditionally, so with an all-zero word the device is reachable only through configuration space.

The block also qualifies parity error events. A data parity error requests a PERR# assertion, and an address parity error requests a SERR# assertion, only when the relevant enable bits are set. Every detected parity error, qualified or not, sets a sticky detected-parity bit in the status word. Software clears that bit by writing a 1 to it.

Top module: `pci_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0x0000, the status word reads 0x0000, and perr_o, serr_o and every claim or grant output are low.
- R2: A write with cfg_addr_i=0 stores the writable bits 9, 8, 6, 4, 2, 1 and 0. be[0] gates bits 7:0 and be[1] gates bits 15:8. A byte whose enable is low keeps its value.
- R3: Bits 15 to 10 and bits 7, 5 and 3 always read 0, whatever value is written to them.
- R4: mem_claim_o follows mem_req_i only while bit 1 is 1. io_claim_o follows io_req_i only while bit 0 is 1. mst_grant_o follows mst_req_i only while bit 2 is 1. cfg_claim_o always follows cfg_req_i.
- R5: A data_perr_i pulse drives perr_o high for exactly the following cycle if bit 6 is 1. If bit 6 is 0, perr_o stays low.
- R6: An addr_perr_i pulse drives serr_o high for the following cycle only when both bit 8 and bit 6 are 1.
- R7: Any parity error pulse sets status bit 15 from the following cycle on, even when bit 6 is 0. The bit holds until it is cleared.
- R8: A write with cfg_addr_i=1, be[1]=1 and wdata bit 15 = 1 clears status bit 15. A detection in the same cycle wins, and the bit stays 1.
- R9: fbb_en_o mirrors bit 9 and mwi_en_o mirrors bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects the command word, 1 selects the status word |
| cfg_be_i | input | 2 | Byte enables |
| cfg_wdata_i | input | 16 | Write data |
| cmd_rdata_o | output | 16 | Command word read value |
| sts_rdata_o | output | 16 | Status word read value (bit 15 only) |
| mem_req_i | input | 1 | Memory-space decode hit |
| io_req_i | input | 1 | I/O-space decode hit |
| cfg_req_i | input | 1 | Configuration decode hit |
| mst_req_i | input | 1 | Master side requests the bus |
| mem_claim_o | output | 1 | Claim memory transaction |
| io_claim_o | output | 1 | Claim I/O transaction |
| cfg_claim_o | output | 1 | Claim configuration transaction |
| mst_grant_o | output | 1 | Master start allowed |
| fbb_en_o | output | 1 | Fast back-to-back to other agents allowed |
| mwi_en_o | output | 1 | Write-and-invalidate allowed |
| addr_perr_i | input | 1 | Address parity error pulse |
| data_perr_i | input | 1 | Data parity error pulse |
| perr_o | output | 1 | PERR# assertion request |
| serr_o | output | 1 | SERR# assertion request |

## Verification
The bench builds the block with its default 16-bit width, which places the byte-enable split at bit 8 and puts the read-only and reserved positions exactly where the requirements fix them. With this width every writable bit can be set and cleared one byte at a time. Each pairing of bits 6 and 8 can be set up before an error pulse, and the clear-versus-detect collision on the status bit can be produced on a single edge.

// File: rtl/pci_cmd_pkg.sv
package pci_cmd_pkg;
  localparam int unsigned IO_B   = 0;
  localparam int unsigned MEM_B  = 1;
  localparam int unsigned MST_B  = 2;
  localparam int unsigned MWI_B  = 4;
  localparam int unsigned PER_B  = 6;
  localparam int unsigned SERR_B = 8;
  localparam int unsigned FBB_B  = 9;
  localparam int unsigned DPE_B  = 15;

  function automatic logic [15:0] rw_mask();
    logic [15:0] m;
    m = '0;
    m[IO_B] = 1'b1; m[MEM_B] = 1'b1; m[MST_B] = 1'b1; m[MWI_B] = 1'b1;
    m[PER_B] = 1'b1; m[SERR_B] = 1'b1; m[FBB_B] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cmd_store.sv
module cmd_store #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = '0,
  localparam int unsigned BE_W = W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [BE_W-1:0] be_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    q_o
);
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b*8 +: 8] <= '0;
      else if (we_i && be_i[b]) q_o[b*8 +: 8] <= wdata_i[b*8 +: 8] & MASK[b*8 +: 8];
    end

    assert_byte_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && be_i[b]) |=> $stable(q_o[b*8 +: 8]));
  end

  assert_fixed_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~MASK) == '0);
endmodule

// File: rtl/perr_qual.sv
module perr_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic per_i,
  input  logic serre_i,
  input  logic addr_perr_i,
  input  logic data_perr_i,
  input  logic clr_i,
  output logic perr_o,
  output logic serr_o,
  output logic dpe_o
);
  logic hit;
  assign hit = addr_perr_i | data_perr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_o <= 1'b0;
      serr_o <= 1'b0;
      dpe_o  <= 1'b0;
    end else begin
      perr_o <= data_perr_i & per_i;
      serr_o <= addr_perr_i & per_i & serre_i;
      if (hit)        dpe_o <= 1'b1;  // detection beats clear
      else if (clr_i) dpe_o <= 1'b0;
    end
  end

  assert_perr_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |-> $past(data_perr_i) && $past(per_i));
  assert_perr_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_perr_i && !per_i) |=> !perr_o);
  assert_serr_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past(addr_perr_i) && $past(per_i) && $past(serre_i));
  assert_dpe_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> dpe_o);
  assert_dpe_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dpe_o) |-> $past(clr_i) && !$past(hit));
endmodule

// File: rtl/pci_cmd_ctrl.sv
module pci_cmd_ctrl
  import pci_cmd_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  localparam int unsigned BE_W = REG_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_addr_i,
  input  logic [BE_W-1:0]  cfg_be_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cmd_rdata_o,
  output logic [REG_W-1:0] sts_rdata_o,
  input  logic             mem_req_i,
  input  logic             io_req_i,
  input  logic             cfg_req_i,
  input  logic             mst_req_i,
  output logic             mem_claim_o,
  output logic             io_claim_o,
  output logic             cfg_claim_o,
  output logic             mst_grant_o,
  output logic             fbb_en_o,
  output logic             mwi_en_o,
  input  logic             addr_perr_i,
  input  logic             data_perr_i,
  output logic             perr_o,
  output logic             serr_o
);
  localparam logic [REG_W-1:0] MASK = REG_W'(rw_mask());

  logic [REG_W-1:0] cmd_q;
  logic             dpe_q;
  logic             sts_clr;

  cmd_store #(.W(REG_W), .MASK(MASK)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && !cfg_addr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (cmd_q)
  );

  assign sts_clr = cfg_we_i && cfg_addr_i && cfg_be_i[DPE_B/8] && cfg_wdata_i[DPE_B];

  perr_qual u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .per_i       (cmd_q[PER_B]),
    .serre_i     (cmd_q[SERR_B]),
    .addr_perr_i (addr_perr_i),
    .data_perr_i (data_perr_i),
    .clr_i       (sts_clr),
    .perr_o      (perr_o),
    .serr_o      (serr_o),
    .dpe_o       (dpe_q)
  );

  always_comb begin
    sts_rdata_o        = '0;
    sts_rdata_o[DPE_B] = dpe_q;
  end

  assign cmd_rdata_o = cmd_q;
  assign mem_claim_o = mem_req_i & cmd_q[MEM_B];
  assign io_claim_o  = io_req_i  & cmd_q[IO_B];
  assign mst_grant_o = mst_req_i & cmd_q[MST_B];
  assign cfg_claim_o = cfg_req_i;  // config space never gated
  assign fbb_en_o    = cmd_q[FBB_B];
  assign mwi_en_o    = cmd_q[MWI_B];

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == '0) |-> !mem_claim_o && !io_claim_o && !mst_grant_o);
endmodule

// File: tb/pci_cmd_ctrl_bench.sv
module pci_cmd_ctrl_bench;
  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, cfg_addr = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cmd_rd, sts_rd;
  logic mem_req = 0, io_req = 0, cfg_req = 0, mst_req = 0;
  logic mem_claim, io_claim, cfg_claim, mst_grant, fbb_en, mwi_en;
  logic addr_perr = 0, data_perr = 0, perr, serr;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  pci_cmd_ctrl u_pci_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cmd_rdata_o(cmd_rd),
    .sts_rdata_o(sts_rd), .mem_req_i(mem_req), .io_req_i(io_req),
    .cfg_req_i(cfg_req), .mst_req_i(mst_req), .mem_claim_o(mem_claim),
    .io_claim_o(io_claim), .cfg_claim_o(cfg_claim), .mst_grant_o(mst_grant),
    .fbb_en_o(fbb_en), .mwi_en_o(mwi_en), .addr_perr_i(addr_perr),
    .data_perr_i(data_perr), .perr_o(perr), .serr_o(serr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_be = 0; cfg_wdata = 0;
  endtask

  task automatic t_reset;
    chk("R1 cmd", cmd_rd, 16'h0);
    chk("R1 sts", sts_rd, 16'h0);
    mem_req = 1; io_req = 1; mst_req = 1; #1;
    chk("R1 outs", {perr, serr, mem_claim, io_claim, mst_grant, fbb_en, mwi_en}, 0);
    mem_req = 0; io_req = 0; mst_req = 0;
  endtask

  task automatic t_write_bytes;
    wr(0, 2'b11, 16'hFFFF);
    chk("R2 R3 all ones", cmd_rd, 16'h0357);
    chk("R9 fbb mwi", {fbb_en, mwi_en}, 2'b11);
    wr(0, 2'b01, 16'h0000);
    chk("R2 low byte only", cmd_rd, 16'h0300);
    wr(0, 2'b10, 16'h0000);
    chk("R2 high byte", cmd_rd, 16'h0000);
    wr(0, 2'b00, 16'hFFFF);
    chk("R2 no enables", cmd_rd, 16'h0000);
    wr(0, 2'b11, 16'hFCA8);
    chk("R3 ro reserved", cmd_rd, 16'h0000);
    chk("R9 off", {fbb_en, mwi_en}, 2'b00);
  endtask

  task automatic t_gating;
    mem_req = 1; io_req = 1; cfg_req = 1; mst_req = 1; #1;
    chk("R4 all zero", {mem_claim, io_claim, mst_grant, cfg_claim}, 4'b0001);
    wr(0, 2'b01, 16'h0002); #1;
    chk("R4 mem only", {mem_claim, io_claim, mst_grant, cfg_claim}, 4'b1001);
    wr(0, 2'b01, 16'h0005); #1;
    chk("R4 io mst", {mem_claim, io_claim, mst_grant, cfg_claim}, 4'b0111);
    mem_req = 0; io_req = 0; cfg_req = 0; mst_req = 0; #1;
    chk("R4 no req", {mem_claim, io_claim, mst_grant, cfg_claim}, 4'b0000);
    wr(0, 2'b11, 16'h0000);
  endtask

  task automatic pulse(logic ap, logic dp, logic exp_perr, logic exp_serr, string req);
    @(negedge clk);
    addr_perr = ap; data_perr = dp;
    @(negedge clk);
    addr_perr = 0; data_perr = 0;
    chk({req, " pulse"}, {perr, serr}, {exp_perr, exp_serr});
    chk("R7 dpe set", sts_rd, 16'h8000);
    @(negedge clk);
    chk({req, " one cycle"}, {perr, serr}, 2'b00);
  endtask

  task automatic t_errors;
    pulse(0, 1, 0, 0, "R5 per off");
    wr(1, 2'b10, 16'h8000);
    chk("R8 clear", sts_rd, 16'h0000);
    wr(0, 2'b01, 16'h0040);
    pulse(0, 1, 1, 0, "R5 per on");
    pulse(1, 0, 0, 0, "R6 serre off");
    wr(0, 2'b11, 16'h0100);
    pulse(1, 0, 0, 0, "R6 per off");
    wr(0, 2'b11, 16'h0140);
    pulse(1, 0, 0, 1, "R6 both on");
    wr(1, 2'b01, 16'h8000);
    chk("R8 wrong byte", sts_rd, 16'h8000);
    wr(1, 2'b10, 16'h7FFF);
    chk("R8 zero written", sts_rd, 16'h8000);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 1; cfg_be = 2'b10; cfg_wdata = 16'h8000; data_perr = 1;
    @(negedge clk);
    cfg_we = 0; cfg_be = 0; cfg_wdata = 0; data_perr = 0;
    chk("R8 detect wins", sts_rd, 16'h8000);
    chk("R8 cmd untouched", cmd_rd, 16'h0140);
    wr(1, 2'b10, 16'h8000);
    chk("R8 clear again", sts_rd, 16'h0000);
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset;
        repeat (2) @(negedge clk);
        rst_ni = 1;
        t_reset;
        t_write_bytes;
        t_gating;
        t_errors;
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule